// File: doc/BRIEF.md
# Debug communications channel mailbox

This block is a two-way, one-word-per-direction mailbox that lets an external debugger and software on a processor core exchange 32-bit words while the core runs normally. The debugger fills the receive word and the core drains it; the core fills the transmit word and the debugger drains it. Each word has a full flag, and both flags are visible to both sides through a status word.

The core reaches the mailbox through a coprocessor-style port: a one-bit register select (status or data), a read strobe and a write strobe. The debugger reaches it through a memory-mapped bus port with a byte address, read and write strobes and a ready signal. Every access completes in the cycle it is presented. Read data is combinational and the register state changes at the next rising clock edge. The debugger side always works in nonblocking mode: a write to a full receive word is dropped rather than stalled. Every access the protocol leaves undefined has a fixed, documented result here.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, both full flags are 0 and both stored words are 0. A status read on either side returns 0, and a core data read returns 0.
- R2: A debugger write to address 0x4 (receive word) while receive-full is 0 stores the write data and sets receive-full to 1.
- R3: A debugger write to address 0x4 while receive-full is 1 is ignored. The stored receive word and the flag stay unchanged, unless R10 applies.
- R4: A core read with select 1 (data) while receive-full is 1 returns the stored receive word in the same cycle and clears receive-full.
- R5: A core data read while receive-full is 0 returns the last stored receive word and leaves receive-full at 0.
- R6: A core write with select 1 while transmit-full is 0 stores the write data and sets transmit-full to 1.
- R7: A core write with select 1 while transmit-full is 1 is dropped. The transmit word and the flag stay unchanged, unless R10 applies.
- R8: A debugger read of address 0x8 (transmit word) returns the stored transmit word. It clears transmit-full if that flag was 1, and leaves the flag at 0 if it was 0.
- R9: The status word has bit 0 = receive-full and bit 1 = transmit-full, with all other bits 0. It is read by the core with select 0 and by the debugger at address 0x0. A status read has no side effects.
- R10: When a drain and a fill of the same word fall in the same cycle, the drain returns the old word, the new word is stored and the flag ends at 1.
- R11: bus_ready is 1 in every cycle with a debugger read or write and 0 in idle cycles. Debugger reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_sel | input | 1 | Core register select: 0 status, 1 data |
| core_rd | input | 1 | Core read strobe |
| core_wr | input | 1 | Core write strobe |
| core_wdata | input | 32 | Core write data |
| core_rdata | output | 32 | Core read data, combinational |
| bus_addr | input | 4 | Debugger byte address: 0x0 status, 0x4 receive, 0x8 transmit |
| bus_rd | input | 1 | Debugger read strobe |
| bus_wr | input | 1 | Debugger write strobe |
| bus_wdata | input | 32 | Debugger write data |
| bus_rdata | output | 32 | Debugger read data, combinational |
| bus_ready | output | 1 | Access complete this cycle |

## Verification
Two functions can fall in one cycle: the drain of a full word by one side and the refill of that same word by the other side. This applies to the core read with a debugger write on the receive word, and to the debugger read with a core write on the transmit word. The bench fills a word, then drives the drain and the refill together in a single cycle. It checks that the drain returns the old word in that cycle. Afterwards it checks that the status shows the word still full and that the next drain returns the new word.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
    localparam int MBOX_OFF_STATUS = 0;
    localparam int MBOX_OFF_RX     = 4;
    localparam int MBOX_OFF_TX     = 8;

    typedef enum logic [1:0] {
        BUS_SEL_NONE   = 2'd0,
        BUS_SEL_STATUS = 2'd1,
        BUS_SEL_RX     = 2'd2,
        BUS_SEL_TX     = 2'd3
    } bus_sel_e;

    localparam logic CORE_SEL_STATUS = 1'b0;
    localparam logic CORE_SEL_DATA   = 1'b1;
endpackage

// File: rtl/dbg_mbox_slot.sv
module dbg_mbox_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fill,
    input  logic [W-1:0] fill_data,
    input  logic         drain,
    output logic         full,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] word;
    } slot_t;

    slot_t s_d, s_q;
    logic  accept;

    always_comb begin
        s_d    = s_q;
        // drain is ordered before fill, so a refill in the drain cycle is kept
        accept = fill && (!s_q.full || drain);
        if (drain) s_d.full = 1'b0;
        if (accept) begin
            s_d.full = 1'b1;
            s_d.word = fill_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full = s_q.full;
    assign word = s_q.word;

    // R2, R6: fill into an empty slot
    assert_fill_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !full) |=> (full && word == $past(fill_data)));
    // R3, R7: fill into a full slot without drain is dropped
    assert_drop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && full && !drain) |=> (full && $stable(word)));
    // R4, R8: drain of a full slot clears it
    assert_drain_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && full && !fill) |=> !full);
    // R5, R8: drain of an empty slot changes nothing
    assert_drain_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !full && !fill) |=> (!full && $stable(word)));
    // R10: same-cycle drain and refill keeps the new word
    assert_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && fill) |=> (full && word == $past(fill_data)));
endmodule

// File: rtl/dbg_mbox_bus_dec.sv
module dbg_mbox_bus_dec
    import dbg_mbox_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              rx_fill,
    output logic              tx_drain,
    output bus_sel_e          rd_sel
);
    always_comb begin
        rd_sel = BUS_SEL_NONE;
        if (addr == ADDR_W'(MBOX_OFF_STATUS))  rd_sel = BUS_SEL_STATUS;
        else if (addr == ADDR_W'(MBOX_OFF_RX)) rd_sel = BUS_SEL_RX;
        else if (addr == ADDR_W'(MBOX_OFF_TX)) rd_sel = BUS_SEL_TX;
    end

    assign rx_fill  = wr && (rd_sel == BUS_SEL_RX);
    assign tx_drain = rd && (rd_sel == BUS_SEL_TX);
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_sel,
    input  logic              core_rd,
    input  logic              core_wr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready
);
    logic              rx_full, tx_full;
    logic [DATA_W-1:0] rx_word, tx_word, status;
    logic              rx_fill, tx_drain, rx_drain, tx_fill;
    bus_sel_e          bus_sel;

    dbg_mbox_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .rx_fill(rx_fill), .tx_drain(tx_drain), .rd_sel(bus_sel)
    );

    assign rx_drain = core_rd && (core_sel == CORE_SEL_DATA);
    assign tx_fill  = core_wr && (core_sel == CORE_SEL_DATA);

    dbg_mbox_slot #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .fill(rx_fill), .fill_data(bus_wdata),
        .drain(rx_drain), .full(rx_full), .word(rx_word)
    );

    dbg_mbox_slot #(.W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .fill(tx_fill), .fill_data(core_wdata),
        .drain(tx_drain), .full(tx_full), .word(tx_word)
    );

    assign status = {{(DATA_W-2){1'b0}}, tx_full, rx_full};

    always_comb begin
        core_rdata = (core_sel == CORE_SEL_DATA) ? rx_word : status;
        unique case (bus_sel)
            BUS_SEL_STATUS: bus_rdata = status;
            BUS_SEL_TX:     bus_rdata = tx_word;
            default:        bus_rdata = '0;
        endcase
    end

    assign bus_ready = bus_rd || bus_wr;

    // R11: ready follows the bus strobes in both directions
    assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |-> !bus_ready);
    // R9: status reads leave both flags as they were
    assert_status_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd && core_sel == CORE_SEL_STATUS && !core_wr && !bus_rd && !bus_wr)
        |=> (rx_full == $past(rx_full) && tx_full == $past(tx_full)));
endmodule

// File: tb/dbg_mailbox_test.sv
module dbg_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_sel = 1'b0, core_rd = 1'b0, core_wr = 1'b0;
    logic [31:0] core_wdata = '0, core_rdata;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_ready;
    int          total = 0, bad = 0;
    logic [31:0] got;

    always #4 clk = ~clk;

    dbg_mailbox uut (
        .clk(clk), .rst_n(rst_n), .core_sel(core_sel), .core_rd(core_rd),
        .core_wr(core_wr), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        core_rd = 0; core_wr = 0; bus_rd = 0; bus_wr = 0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        #2 check("R11 ready on write", {31'b0, bus_ready}, 32'd1);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #2 d = bus_rdata;
        check("R11 ready on read", {31'b0, bus_ready}, 32'd1);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic core_read(input logic s, output logic [31:0] d);
        @(negedge clk);
        core_sel = s; core_rd = 1;
        #2 d = core_rdata;
        @(negedge clk);
        core_rd = 0;
    endtask

    task automatic core_write(input logic [31:0] d);
        @(negedge clk);
        core_sel = 1; core_wdata = d; core_wr = 1;
        @(negedge clk);
        core_wr = 0;
    endtask

    task automatic t_reset();
        bus_read(4'h0, got);  check("R1 bus status", got, 32'd0);
        core_read(1'b0, got); check("R1 core status", got, 32'd0);
        core_read(1'b1, got); check("R1 core data", got, 32'd0);
        bus_read(4'h8, got);  check("R1 tx word", got, 32'd0);
        #1 check("R11 idle ready", {31'b0, bus_ready}, 32'd0);
    endtask

    task automatic t_receive();
        bus_write(4'h4, 32'hA5A5_0001);
        core_read(1'b0, got); check("R2 rx full set", got, 32'd1);
        bus_write(4'h4, 32'hDEAD_BEEF);
        core_read(1'b0, got); check("R3 flag kept", got, 32'd1);
        core_read(1'b1, got); check("R4 R3 word kept", got, 32'hA5A5_0001);
        core_read(1'b0, got); check("R4 rx full cleared", got, 32'd0);
        core_read(1'b1, got); check("R5 stale word", got, 32'hA5A5_0001);
        bus_read(4'h0, got);  check("R5 flag stays 0", got, 32'd0);
        bus_read(4'h4, got);  check("R11 unmapped read", got, 32'd0);
    endtask

    task automatic t_transmit();
        core_write(32'h1234_5678);
        bus_read(4'h0, got); check("R6 tx full set", got, 32'd2);
        core_write(32'h0BAD_0BAD);
        bus_read(4'h0, got); check("R7 flag kept", got, 32'd2);
        bus_read(4'h8, got); check("R8 R7 word kept", got, 32'h1234_5678);
        bus_read(4'h0, got); check("R8 tx full cleared", got, 32'd0);
        bus_read(4'h8, got); check("R8 stale word", got, 32'h1234_5678);
        bus_read(4'h0, got); check("R8 flag stays 0", got, 32'd0);
    endtask

    task automatic t_status();
        bus_write(4'h4, 32'h0000_00C3);
        core_write(32'h0000_003C);
        for (int i = 0; i < 3; i++) begin
            core_read(1'b0, got); check("R9 core status both", got, 32'd3);
            bus_read(4'h0, got);  check("R9 bus status both", got, 32'd3);
        end
        core_read(1'b1, got); check("R9 rx word intact", got, 32'h0000_00C3);
        bus_read(4'h8, got);  check("R9 tx word intact", got, 32'h0000_003C);
    endtask

    task automatic t_same_cycle();
        bus_write(4'h4, 32'h0000_0E0E);
        @(negedge clk);
        core_sel = 1; core_rd = 1;
        bus_addr = 4'h4; bus_wdata = 32'h0000_0F0F; bus_wr = 1;
        #2 check("R10 rx drain old", core_rdata, 32'h0000_0E0E);
        idle();
        core_read(1'b0, got); check("R10 rx stays full", got, 32'd1);
        core_read(1'b1, got); check("R10 rx new word", got, 32'h0000_0F0F);
        core_write(32'h0000_0A0A);
        @(negedge clk);
        core_sel = 1; core_wdata = 32'h0000_0B0B; core_wr = 1;
        bus_addr = 4'h8; bus_rd = 1;
        #2 check("R10 tx drain old", bus_rdata, 32'h0000_0A0A);
        idle();
        bus_read(4'h0, got); check("R10 tx stays full", got, 32'd2);
        bus_read(4'h8, got); check("R10 tx new word", got, 32'h0000_0B0B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_receive();
        t_transmit();
        t_status();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule